// File: doc/BRIEF.md
# DDR Mode Register Initialisation Sequencer

This block brings a DDR or DDR2 SDRAM into a known configuration after power-up. Software programs the operating fields: read latency (CAS), additive latency, write recovery and a burst-length choice. It also programs three wait counts. When the memory enable input is raised and the bypass input is clear, the block steps through a fixed command sequence. It first waits a programmable power-up interval. It then issues a precharge-all once every bank reports idle. After that it writes the extended mode register, then the main mode register, and finally waits a recovery interval before it raises an initialisation-done flag.

Each command leaves the block as a one-cycle request toward the downstream command issuer. The request carries a command code, a bank select and an address word. In DDR1 mode the fields that only DDR2 defines are packed as zero. In DDR2 mode only four-beat bursts are written. Sequential burst ordering is always selected.

When bypass is set, the automatic sequence never runs. Software can then drive single mode register writes through a request/acknowledge pair. Each write carries a bank select and a raw address word, and the block accepts it only while it is idle.

Top module: `mrs_init_seq`

## Requirements
- R1: While and directly after reset, `cmd_valid`, `man_ack` and `init_done` are low and `cmd_code` is 00.
- R2: No command is issued and `init_done` stays low while `mem_en` is low; the automatic sequence starts on the first clock edge that sees `mem_en` high with `bypass` low.
- R3: The first command of the sequence is precharge-all (`cmd_code` 01, bank 0, address bit 10 high, all other address bits zero). It is issued only on an edge where `banks_idle` is high, and no earlier than `pre_wait`+1 cycles after the start edge.
- R4: After precharge-all, the block writes the extended mode register (`cmd_code` 10, bank 1) and then the main mode register (`cmd_code` 10, bank 0). Each command is exactly `cmd_gap`+1 cycles after the previous one, and exactly three commands are issued.
- R5: The main mode word is laid out as follows: bits 2:0 hold the burst length (010 = four beats, 011 = eight beats), bit 3 is burst type and is always 0 (sequential), bits 6:4 hold `cas_lat`, bits 11:9 hold `wr_rec`, and all other bits are 0.
- R6: The extended mode word carries `add_lat` in bits 5:3, and all other bits are 0.
- R7: With `ddr2` low, the write recovery field (bits 11:9) and the additive latency field (bits 5:3) are written as zero, whatever their inputs hold.
- R8: With `ddr2` high, the burst length field is always 010, even when `bl8` is set; with `ddr2` low, `bl8` selects 011.
- R9: `init_done` rises exactly `recov_wait`+1 cycles after the main mode register command. It then stays high until reset, and the sequence never repeats.
- R10: With `bypass` high, no automatic command is issued and `init_done` stays low.
- R11: With `bypass` high and the block idle, a `man_req` seen on an edge causes one mode register command (`cmd_code` 10) carrying `man_bank` and `man_data` in the next cycle. `man_ack` follows one cycle after that command and lasts one cycle.
- R12: With `bypass` low, `man_req` is ignored: it produces no command and no `man_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Memory enable; starts the automatic sequence |
| bypass | input | 1 | Skip the automatic sequence and allow manual writes |
| ddr2 | input | 1 | 1 = DDR2 field packing, 0 = DDR1 |
| cas_lat | input | 3 | CAS latency field |
| add_lat | input | 3 | Additive latency field (DDR2 only) |
| wr_rec | input | 3 | Write recovery field (DDR2 only) |
| bl8 | input | 1 | Request eight-beat bursts (honoured in DDR1 only) |
| pre_wait | input | CNT_W | Power-up wait before precharge-all |
| cmd_gap | input | CNT_W | Extra cycles between successive commands |
| recov_wait | input | CNT_W | Extra cycles after the last mode write before done |
| banks_idle | input | 1 | All banks idle; precharge-all is held until this is high |
| man_req | input | 1 | Manual mode register write request |
| man_bank | input | BANK_W | Bank select for the manual write |
| man_data | input | ADDR_W | Address word for the manual write |
| man_ack | output | 1 | One-cycle acknowledge after a manual write is issued |
| cmd_valid | output | 1 | One-cycle command request |
| cmd_code | output | 2 | 00 none, 01 precharge-all, 10 mode register set |
| cmd_bank | output | BANK_W | Bank select of the command |
| cmd_addr | output | ADDR_W | Address word of the command |
| init_done | output | 1 | Initialisation complete |

## Verification
The bench holds `banks_idle` low well past the power-up wait. A design that ignored it would precharge while rows were still open. The bench also runs a zero command gap, which forces back-to-back requests; a counter that is off by one would spread or merge them. It programs nonzero additive latency, nonzero write recovery and an eight-beat burst request in both modes, so a packer that leaked DDR2-only fields into DDR1, or wrote eight-beat bursts in DDR2, would show a wrong mode word. Finally, it raises `man_req` with bypass clear, and toggles `mem_en` after completion, to catch manual writes that slip in outside bypass and sequences that restart.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_PREA = 2'b01,
    CMD_MRS  = 2'b10
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PREWAIT,
    S_GAP1,
    S_GAP2,
    S_RECOV,
    S_DONE,
    S_MAN_ACK,
    S_MAN_END
  } seq_st_e;

  localparam int PREA_ALL_BIT = 10;
  localparam int EMR_BANK     = 1;
  localparam int MR_BANK      = 0;
endpackage

// File: rtl/mrs_wait_timer.sv
module mrs_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/mrs_mode_packer.sv
module mrs_mode_packer #(
  parameter int ADDR_W = 14
) (
  input  logic              ddr2,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        add_lat,
  input  logic [2:0]        wr_rec,
  input  logic              bl8,
  output logic [ADDR_W-1:0] mr_word,
  output logic [ADDR_W-1:0] emr_word
);
  localparam logic [2:0] BL_FOUR  = 3'b010;
  localparam logic [2:0] BL_EIGHT = 3'b011;

  logic [2:0] bl_field;
  logic [2:0] wr_field;
  logic [2:0] al_field;

  always_comb begin
    // eight-beat bursts only in DDR1 mode; DDR2-only fields zeroed in DDR1
    bl_field = (bl8 && !ddr2) ? BL_EIGHT : BL_FOUR;
    wr_field = ddr2 ? wr_rec  : 3'b000;
    al_field = ddr2 ? add_lat : 3'b000;

    mr_word        = '0;
    mr_word[2:0]   = bl_field;
    mr_word[3]     = 1'b0;          // sequential ordering
    mr_word[6:4]   = cas_lat;
    mr_word[11:9]  = wr_field;

    emr_word       = '0;
    emr_word[5:3]  = al_field;
  end
endmodule

// File: rtl/mrs_init_seq.sv
module mrs_init_seq
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en,
  input  logic              bypass,
  input  logic              ddr2,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        add_lat,
  input  logic [2:0]        wr_rec,
  input  logic              bl8,
  input  logic [CNT_W-1:0]  pre_wait,
  input  logic [CNT_W-1:0]  cmd_gap,
  input  logic [CNT_W-1:0]  recov_wait,
  input  logic              banks_idle,
  input  logic              man_req,
  input  logic [BANK_W-1:0] man_bank,
  input  logic [ADDR_W-1:0] man_data,
  output logic              man_ack,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              init_done
);
  localparam logic [BANK_W-1:0] EMR_BA = BANK_W'(EMR_BANK);
  localparam logic [BANK_W-1:0] MR_BA  = BANK_W'(MR_BANK);
  localparam logic [ADDR_W-1:0] PREA_WORD = ADDR_W'(1) << PREA_ALL_BIT;

  seq_st_e st_q;
  logic [ADDR_W-1:0] mr_word, emr_word;
  logic tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic go_start, go_man, go_pre, go_emr, go_mr, go_done;

  mrs_mode_packer #(.ADDR_W(ADDR_W)) u_pack (
    .ddr2    (ddr2),
    .cas_lat (cas_lat),
    .add_lat (add_lat),
    .wr_rec  (wr_rec),
    .bl8     (bl8),
    .mr_word (mr_word),
    .emr_word(emr_word)
  );

  mrs_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_zero)
  );

  always_comb begin
    go_start = (st_q == S_IDLE) && mem_en && !bypass && !init_done;
    go_man   = (st_q == S_IDLE) && bypass && man_req;
    go_pre   = (st_q == S_PREWAIT) && tmr_zero && banks_idle;
    go_emr   = (st_q == S_GAP1) && tmr_zero;
    go_mr    = (st_q == S_GAP2) && tmr_zero;
    go_done  = (st_q == S_RECOV) && tmr_zero;
    tmr_load = go_start || go_pre || go_emr || go_mr;
    if (go_start)   tmr_val = pre_wait;
    else if (go_mr) tmr_val = recov_wait;
    else            tmr_val = cmd_gap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NONE;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      man_ack   <= 1'b0;
      init_done <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      man_ack   <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (go_start) begin
            st_q <= S_PREWAIT;
          end else if (go_man) begin
            cmd_valid <= 1'b1;
            cmd_code  <= CMD_MRS;
            cmd_bank  <= man_bank;
            cmd_addr  <= man_data;
            st_q      <= S_MAN_ACK;
          end
        end
        S_PREWAIT: if (go_pre) begin
          cmd_valid <= 1'b1;
          cmd_code  <= CMD_PREA;
          cmd_bank  <= '0;
          cmd_addr  <= PREA_WORD;
          st_q      <= S_GAP1;
        end
        S_GAP1: if (go_emr) begin
          cmd_valid <= 1'b1;
          cmd_code  <= CMD_MRS;
          cmd_bank  <= EMR_BA;
          cmd_addr  <= emr_word;
          st_q      <= S_GAP2;
        end
        S_GAP2: if (go_mr) begin
          cmd_valid <= 1'b1;
          cmd_code  <= CMD_MRS;
          cmd_bank  <= MR_BA;
          cmd_addr  <= mr_word;
          st_q      <= S_RECOV;
        end
        S_RECOV: if (go_done) begin
          init_done <= 1'b1;
          st_q      <= S_DONE;
        end
        S_DONE: st_q <= S_DONE;
        S_MAN_ACK: begin
          man_ack <= 1'b1;
          st_q    <= S_MAN_END;
        end
        S_MAN_END: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mrs_init_seq_chk.sv
module mrs_init_seq_chk #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bypass,
  input logic              banks_idle,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              man_ack,
  input logic              init_done
);
  // R3: precharge-all only on an edge that saw every bank idle
  p_pre_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 2'b01) |-> $past(banks_idle));

  // R4: a request always carries a real command code
  p_code_legal_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_code == 2'b01 || cmd_code == 2'b10));

  // R5: automatic main mode writes always select sequential bursts
  p_seq_burst_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 2'b10 && cmd_bank == '0 && !$past(bypass))
      |-> !cmd_addr[3]);

  // R9: done is sticky
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R11: acknowledge follows an issued command
  p_ack_after_cmd_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(man_ack) |-> $past(cmd_valid));

  // R11: acknowledge lasts one cycle
  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    man_ack |=> !man_ack);
endmodule

bind mrs_init_seq mrs_init_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bypass    (bypass),
  .banks_idle(banks_idle),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .cmd_bank  (cmd_bank),
  .cmd_addr  (cmd_addr),
  .man_ack   (man_ack),
  .init_done (init_done)
);

// File: tb/mrs_init_seq_test.sv
module mrs_init_seq_test;
  localparam int ADDR_W = 14;
  localparam int BANK_W = 2;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_en = 1'b0, bypass = 1'b0, ddr2 = 1'b0, bl8 = 1'b0;
  logic [2:0] cas_lat = '0, add_lat = '0, wr_rec = '0;
  logic [CNT_W-1:0] pre_wait = '0, cmd_gap = '0, recov_wait = '0;
  logic banks_idle = 1'b0, man_req = 1'b0;
  logic [BANK_W-1:0] man_bank = '0;
  logic [ADDR_W-1:0] man_data = '0;
  logic man_ack, cmd_valid, init_done;
  logic [1:0] cmd_code;
  logic [BANK_W-1:0] cmd_bank;
  logic [ADDR_W-1:0] cmd_addr;

  always #10 clk = ~clk;

  mrs_init_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .mem_en(mem_en), .bypass(bypass), .ddr2(ddr2),
    .cas_lat(cas_lat), .add_lat(add_lat), .wr_rec(wr_rec), .bl8(bl8),
    .pre_wait(pre_wait), .cmd_gap(cmd_gap), .recov_wait(recov_wait),
    .banks_idle(banks_idle), .man_req(man_req), .man_bank(man_bank),
    .man_data(man_data), .man_ack(man_ack), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .init_done(init_done)
  );

  typedef struct {
    logic [1:0]        code;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
    string             tag;
  } item_t;

  item_t exp_q[$];
  int cmd_t[$];
  int ack_t[$];
  int done_t = -1;
  int cyc = 0;
  int nchk = 0;
  int nfail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // monitor: pops expected commands and compares
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin
        cmd_t.push_back(cyc);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected command code", cmd_code, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(cmd_code == e.code, e.tag, "command code", cmd_code, e.code);
          chk(cmd_bank == e.bank, e.tag, "bank", cmd_bank, e.bank);
          chk(cmd_addr == e.addr, e.tag, "address word", cmd_addr, e.addr);
        end
      end
      if (man_ack) ack_t.push_back(cyc);
      if (init_done && done_t < 0) done_t = cyc;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    finish_up();
  end

  function automatic logic [ADDR_W-1:0] exp_mr(input bit d2, input logic [2:0] cl,
                                                input logic [2:0] wr, input bit b8);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[2:0]  = (b8 && !d2) ? 3'b011 : 3'b010;   // R5, R8
    w[6:4]  = cl;
    w[11:9] = d2 ? wr : 3'b000;                // R7
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_emr(input bit d2, input logic [2:0] al);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[5:3] = d2 ? al : 3'b000;                 // R6, R7
    return w;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mem_en = 1'b0; bypass = 1'b0; man_req = 1'b0; banks_idle = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !man_ack && !init_done && cmd_code == 2'b00, "R1",
        "outputs in reset", {cmd_valid, man_ack, init_done, cmd_code}, 0);
    rst = 1'b0;
    cmd_t.delete(); ack_t.delete(); exp_q.delete(); done_t = -1;
    @(negedge clk);
    chk(!cmd_valid && !man_ack && !init_done, "R1", "outputs after reset",
        {cmd_valid, man_ack, init_done}, 0);
  endtask

  task automatic run_auto(input bit d2, input logic [2:0] cl, input logic [2:0] al,
                          input logic [2:0] wr, input bit b8, input int pw,
                          input int gp, input int rc, input int hold);
    int s, pre_exp, r;
    item_t it;
    do_reset();
    ddr2 = d2; cas_lat = cl; add_lat = al; wr_rec = wr; bl8 = b8;
    pre_wait = CNT_W'(pw); cmd_gap = CNT_W'(gp); recov_wait = CNT_W'(rc);
    banks_idle = (hold == 0);
    repeat (10) @(negedge clk);
    chk(cmd_t.size() == 0 && !init_done, "R2", "idle while mem_en low",
        cmd_t.size(), 0);
    it.code = 2'b01; it.bank = '0; it.addr = ADDR_W'(1) << 10; it.tag = "R3";
    exp_q.push_back(it);
    it.code = 2'b10; it.bank = 2'd1; it.addr = exp_emr(d2, al);
    it.tag = d2 ? "R6" : "R7";
    exp_q.push_back(it);
    it.code = 2'b10; it.bank = 2'd0; it.addr = exp_mr(d2, cl, wr, b8);
    it.tag = d2 ? "R8" : "R5";
    exp_q.push_back(it);
    s = cyc;
    mem_en = 1'b1;
    pre_exp = s + 1 + pw + 1;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(cmd_t.size() == 0, "R3", "no precharge while banks busy", cmd_t.size(), 0);
      r = cyc;
      banks_idle = 1'b1;
      pre_exp = (r + 1 > pre_exp) ? r + 1 : pre_exp;
    end
    for (int i = 0; i < 400 && !init_done; i++) @(negedge clk);
    @(negedge clk);
    chk(cmd_t.size() == 3, "R4", "command count", cmd_t.size(), 3);
    if (cmd_t.size() == 3) begin
      chk(cmd_t[0] == pre_exp, "R3", "precharge cycle", cmd_t[0], pre_exp);
      chk(cmd_t[1] - cmd_t[0] == gp + 1, "R4", "gap pre->emr", cmd_t[1] - cmd_t[0], gp + 1);
      chk(cmd_t[2] - cmd_t[1] == gp + 1, "R4", "gap emr->mr", cmd_t[2] - cmd_t[1], gp + 1);
      chk(done_t - cmd_t[2] == rc + 1, "R9", "done delay", done_t - cmd_t[2], rc + 1);
    end
    chk(exp_q.size() == 0, "R4", "expected commands left", exp_q.size(), 0);
    mem_en = 1'b0;
    repeat (5) @(negedge clk);
    mem_en = 1'b1;
    repeat (30) @(negedge clk);
    chk(cmd_t.size() == 3 && init_done, "R9", "no restart, done held",
        {cmd_t.size(), init_done}, {32'd3, 1'b1});
  endtask

  task automatic man_write(input logic [BANK_W-1:0] ba, input logic [ADDR_W-1:0] d);
    item_t it;
    int a, n0, k0;
    it.code = 2'b10; it.bank = ba; it.addr = d; it.tag = "R11";
    exp_q.push_back(it);
    n0 = cmd_t.size(); k0 = ack_t.size();
    man_bank = ba; man_data = d; man_req = 1'b1;
    a = cyc;
    for (int i = 0; i < 20 && !man_ack; i++) @(negedge clk);
    man_req = 1'b0;
    @(negedge clk);
    chk(cmd_t.size() == n0 + 1 && ack_t.size() == k0 + 1, "R11",
        "one command and one ack", cmd_t.size() - n0, 1);
    if (cmd_t.size() == n0 + 1 && ack_t.size() == k0 + 1) begin
      chk(cmd_t[n0] == a + 1, "R11", "command cycle", cmd_t[n0], a + 1);
      chk(ack_t[k0] == a + 2, "R11", "ack cycle", ack_t[k0], a + 2);
    end
    chk(!man_ack, "R11", "ack width", man_ack, 0);
  endtask

  initial begin
    // DDR2: eight-beat request folded to four, DDR2 fields kept, banks busy first
    run_auto(1'b1, 3'd4, 3'd2, 3'd3, 1'b1, 6, 3, 5, 20);
    // DDR1: DDR2-only fields zeroed, eight-beat honoured, zero gap
    run_auto(1'b0, 3'd3, 3'd5, 3'd6, 1'b1, 3, 0, 2, 0);
    // DDR1 four-beat
    run_auto(1'b0, 3'd2, 3'd7, 3'd7, 1'b0, 0, 1, 0, 0);

    // R10 / R11: bypass
    do_reset();
    bypass = 1'b1; banks_idle = 1'b1; mem_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(cmd_t.size() == 0 && !init_done, "R10", "bypass blocks sequence",
        cmd_t.size(), 0);
    man_write(2'd2, 14'h0abc);
    repeat (3) @(negedge clk);
    man_write(2'd1, 14'h3008);
    repeat (10) @(negedge clk);
    chk(!init_done, "R10", "done low in bypass", init_done, 0);

    // R12: manual request ignored without bypass
    do_reset();
    bypass = 1'b0; mem_en = 1'b0; man_bank = 2'd3; man_data = 14'h1234;
    man_req = 1'b1;
    repeat (15) @(negedge clk);
    man_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_t.size() == 0 && ack_t.size() == 0, "R12", "manual ignored",
        cmd_t.size() + ack_t.size(), 0);

    finish_up();
  end
endmodule